// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Levels

This block buffers audio samples between a 32-bit register port and a serial frame engine. It has a transmit FIFO that the register side fills and the frame engine drains, and a receive FIFO that the frame engine fills and the register side drains. The FIFOs, the control fields and the request logic all run on one system clock. The serial bit clock enters as a single-cycle tick strobe, `sclk_tick_i`.

Software turns the block on by setting the module enable and the run bit, then waits for the standby-release delay. After that it enables each direction on its own. Clearing a FIFO and echoing the sync bit both wait for serial-clock ticks. Software can therefore write the sync bit and poll it to confirm that the bit clock is alive.

Each direction drives a DMA request line and a more urgent panic line. Each line compares the fill level against its own programmable 8-bit level. Two sticky error flags record a transmit underrun and a receive overrun.

Top module: `audio_fifo_dreq`

## Requirements
- R1: After reset, the control word at address 0 reads 0x0000_5000 (transmit empty at bit 12, transmit needs-writing at bit 14), and all four request and panic outputs are low.
- R2: Words written to address 1 appear on `tx_data_o` in write order, and each accepted `tx_pop_i` moves to the next word. Words pushed with `rx_push_i` read back from address 1 in push order, and each read of address 1 pops one word. Reading an empty receive FIFO returns 0.
- R3: A serial-side pop or push is ignored, and sets no error, unless enable (bit 0), run (bit 17), the ready flag and that direction's on bit are all set. The on bits are transmit on (bit 2) and receive on (bit 1).
- R4: The ready flag (bit 18) sets on the fourth serial tick counted while enable and run are both set. It clears when either of them drops.
- R5: Writing 1 to transmit clear (bit 3) or receive clear (bit 4) empties that FIFO only on the second serial tick after the write. After one tick the FIFO still holds its data.
- R6: A value written to the sync bit (bit 16) reads back at bit 16 only after two serial ticks.
- R7: A pop from an empty transmit FIFO while the transmit direction is active sets the transmit error flag (bit 10). The flag stays set until software writes 1 to bit 10.
- R8: A push into a full receive FIFO (64 words) while the receive direction is active sets the receive error flag (bit 11), and the word is dropped. Writing 1 to bit 11 clears the flag.
- R9: Transmit needs-writing (bit 14) is set when the transmit fill is below t×16, where t is the threshold in bits 6:5. When t=0 it means the FIFO is empty. Receive needs-reading (bit 15) is set when the receive fill is at least r×16, where r is the threshold in bits 8:7. When r=0 it means the FIFO is not empty.
- R10: The level word at address 2 holds four levels: transmit panic in bits 31:24, receive panic in 23:16, transmit request in 15:8 and receive request in 7:0. When DMA enable (bit 9) is set, a transmit line is high while the fill is below its level, and a receive line is high while the fill is above its level. When DMA enable is clear, all four lines are low.
- R11: Transmit empty (bit 12) and receive holds-data (bit 13) track the fill levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_tick_i | input | 1 | One-cycle strobe per serial bit clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| reg_addr_i | input | 2 | 0 control/status, 1 data, 2 levels |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current address |
| tx_pop_i | input | 1 | Frame engine takes one transmit word |
| tx_data_o | output | 32 | Head of the transmit FIFO (0 when empty) |
| rx_push_i | input | 1 | Frame engine delivers one receive word |
| rx_data_i | input | 32 | Receive word |
| tx_dreq_o | output | 1 | Transmit DMA request |
| tx_panic_o | output | 1 | Transmit panic request |
| rx_dreq_o | output | 1 | Receive DMA request |
| rx_panic_o | output | 1 | Receive panic request |

## Verification
The bench counts serial ticks exactly for the clear, sync and standby delays. A design that acted on the first tick, or acted on system clocks instead of ticks, shows an empty FIFO or the new sync value one tick early. It fills the receive FIFO to exactly 64 words and pushes once more. An off-by-one full test would then either lose word 63 or fail to raise the overrun flag. It walks the fill level across each threshold and each request or panic level by one word. A swapped comparison direction, or a `<=` written where `<` is meant, flips the flag at the wrong count.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DATA = 2'd1,
    A_LVL  = 2'd2
  } reg_addr_e;

  localparam int B_EN     = 0;
  localparam int B_RXON   = 1;
  localparam int B_TXON   = 2;
  localparam int B_TXCLR  = 3;
  localparam int B_RXCLR  = 4;
  localparam int B_TXTHR  = 5;
  localparam int B_RXTHR  = 7;
  localparam int B_DMAEN  = 9;
  localparam int B_TXERR  = 10;
  localparam int B_RXERR  = 11;
  localparam int B_TXMT   = 12;
  localparam int B_RXDAT  = 13;
  localparam int B_TXNEED = 14;
  localparam int B_RXNEED = 15;
  localparam int B_SYNC   = 16;
  localparam int B_RUN    = 17;
  localparam int B_READY  = 18;
endpackage

// File: rtl/afifo_ring.sv
module afifo_ring #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push_i && (count_o != CW'(DEPTH));
  assign do_pop  = pop_i && (count_o != '0);
  assign rdata_o = (count_o == '0) ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/afifo_sclk_seq.sv
module afifo_sclk_seq #(
  parameter int unsigned CLR_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_TICKS  = 4,
  localparam int unsigned CCW = $clog2(CLR_TICKS + 1),
  localparam int unsigned WCW = $clog2(WAKE_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] clr_req_i,   // [0] tx, [1] rx
  output logic [1:0] flush_o,
  input  logic       sync_i,
  output logic       sync_o,
  input  logic       en_run_i,
  output logic       ready_o
);
  // clear delay per direction
  for (genvar d = 0; d < 2; d++) begin : g_clr
    logic [CCW-1:0] cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt <= '0;
      else if (clr_req_i[d])          cnt <= CCW'(CLR_TICKS);
      else if (tick_i && cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign flush_o[d] = tick_i && !clr_req_i[d] && (cnt == CCW'(1));
  end

  logic [SYNC_STAGES-1:0] sync_sh;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sync_sh <= '0;
    else if (tick_i) sync_sh <= {sync_sh[SYNC_STAGES-2:0], sync_i};
  end
  assign sync_o = sync_sh[SYNC_STAGES-1];

  logic [WCW-1:0] wake_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  wake_cnt <= '0;
    else if (!en_run_i)                           wake_cnt <= '0;
    else if (tick_i && wake_cnt != WCW'(WAKE_TICKS)) wake_cnt <= wake_cnt + 1'b1;
  end
  assign ready_o = (wake_cnt == WCW'(WAKE_TICKS));
endmodule

// File: rtl/audio_fifo_dreq.sv
module audio_fifo_dreq
  import afifo_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned LW          = 8,
  parameter int unsigned CLR_TICKS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_TICKS  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_tick_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_dreq_o,
  output logic          tx_panic_o,
  output logic          rx_dreq_o,
  output logic          rx_panic_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam int unsigned MW = (CW > LW) ? CW : LW;

  logic en_q, run_q, txon_q, rxon_q, dmaen_q, sync_q, tx_err_q, rx_err_q;
  logic [1:0] tx_thr_q, rx_thr_q;
  logic [4*LW-1:0] lvl_q;

  logic ctrl_we, data_we, lvl_we, data_re;
  logic tx_err_clr, rx_err_clr, tx_err_set, rx_err_set;
  logic [1:0] flush;
  logic sync_rd, ready, en_run, tx_active, rx_active;
  logic [CW-1:0] tx_count, rx_count;
  logic [DW-1:0] rx_head;
  logic tx_need, rx_need;
  logic [31:0] ctrl_rd;

  assign ctrl_we    = reg_we_i && (reg_addr_i == A_CTRL);
  assign data_we    = reg_we_i && (reg_addr_i == A_DATA);
  assign lvl_we     = reg_we_i && (reg_addr_i == A_LVL);
  assign data_re    = reg_re_i && (reg_addr_i == A_DATA);
  assign tx_err_clr = ctrl_we && reg_wdata_i[B_TXERR];
  assign rx_err_clr = ctrl_we && reg_wdata_i[B_RXERR];

  assign en_run    = en_q && run_q;
  assign tx_active = en_run && ready && txon_q;
  assign rx_active = en_run && ready && rxon_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; run_q <= 1'b0; txon_q <= 1'b0; rxon_q <= 1'b0;
      dmaen_q <= 1'b0; sync_q <= 1'b0; tx_thr_q <= '0; rx_thr_q <= '0;
    end else if (ctrl_we) begin
      en_q     <= reg_wdata_i[B_EN];
      run_q    <= reg_wdata_i[B_RUN];
      txon_q   <= reg_wdata_i[B_TXON];
      rxon_q   <= reg_wdata_i[B_RXON];
      dmaen_q  <= reg_wdata_i[B_DMAEN];
      sync_q   <= reg_wdata_i[B_SYNC];
      tx_thr_q <= reg_wdata_i[B_TXTHR +: 2];
      rx_thr_q <= reg_wdata_i[B_RXTHR +: 2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (lvl_we) lvl_q <= reg_wdata_i[4*LW-1:0];
  end

  assign tx_err_set = tx_pop_i && tx_active && (tx_count == '0);
  assign rx_err_set = rx_push_i && rx_active && (rx_count == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_err_q <= 1'b0;
      rx_err_q <= 1'b0;
    end else begin
      tx_err_q <= tx_err_set || (tx_err_q && !tx_err_clr);
      rx_err_q <= rx_err_set || (rx_err_q && !rx_err_clr);
    end
  end

  afifo_sclk_seq #(
    .CLR_TICKS(CLR_TICKS), .SYNC_STAGES(SYNC_STAGES), .WAKE_TICKS(WAKE_TICKS)
  ) u_seq (
    .clk_i, .rst_ni,
    .tick_i    (sclk_tick_i),
    .clr_req_i ({ctrl_we && reg_wdata_i[B_RXCLR], ctrl_we && reg_wdata_i[B_TXCLR]}),
    .flush_o   (flush),
    .sync_i    (sync_q),
    .sync_o    (sync_rd),
    .en_run_i  (en_run),
    .ready_o   (ready)
  );

  afifo_ring #(.DW(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .flush_i (flush[0]),
    .push_i  (data_we),
    .wdata_i (DW'(reg_wdata_i)),
    .pop_i   (tx_pop_i && tx_active),
    .rdata_o (tx_data_o),
    .count_o (tx_count)
  );

  afifo_ring #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .flush_i (flush[1]),
    .push_i  (rx_push_i && rx_active),
    .wdata_i (rx_data_i),
    .pop_i   (data_re),
    .rdata_o (rx_head),
    .count_o (rx_count)
  );

  function automatic logic [CW-1:0] quarter_mark(logic [1:0] t);
    return CW'(t) * CW'(DEPTH / 4);
  endfunction

  assign tx_need = (tx_thr_q == 2'd0) ? (tx_count == '0) : (tx_count < quarter_mark(tx_thr_q));
  assign rx_need = (rx_thr_q == 2'd0) ? (rx_count != '0) : (rx_count >= quarter_mark(rx_thr_q));

  assign tx_dreq_o  = dmaen_q && (MW'(tx_count) < MW'(lvl_q[2*LW-1:LW]));
  assign tx_panic_o = dmaen_q && (MW'(tx_count) < MW'(lvl_q[4*LW-1:3*LW]));
  assign rx_dreq_o  = dmaen_q && (MW'(rx_count) > MW'(lvl_q[LW-1:0]));
  assign rx_panic_o = dmaen_q && (MW'(rx_count) > MW'(lvl_q[3*LW-1:2*LW]));

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[B_EN]       = en_q;
    ctrl_rd[B_RXON]     = rxon_q;
    ctrl_rd[B_TXON]     = txon_q;
    ctrl_rd[B_TXTHR+:2] = tx_thr_q;
    ctrl_rd[B_RXTHR+:2] = rx_thr_q;
    ctrl_rd[B_DMAEN]    = dmaen_q;
    ctrl_rd[B_TXERR]    = tx_err_q;
    ctrl_rd[B_RXERR]    = rx_err_q;
    ctrl_rd[B_TXMT]     = (tx_count == '0);
    ctrl_rd[B_RXDAT]    = (rx_count != '0);
    ctrl_rd[B_TXNEED]   = tx_need;
    ctrl_rd[B_RXNEED]   = rx_need;
    ctrl_rd[B_SYNC]     = sync_rd;
    ctrl_rd[B_RUN]      = run_q;
    ctrl_rd[B_READY]    = ready;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_rd;
      A_DATA:  reg_rdata_o = 32'(rx_head);
      A_LVL:   reg_rdata_o = 32'(lvl_q);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/afifo_dreq_chk.sv
module afifo_dreq_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick,
  input logic [1:0]    flush,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_err,
  input logic          rx_err,
  input logic          tx_err_clr,
  input logic          rx_err_clr,
  input logic          en_run,
  input logic          ready,
  input logic          sync_rd
);
  p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  p_tx_clr_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush[0] |=> (tx_count == '0));

  p_rx_clr_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush[1] |=> (rx_count == '0));

  p_txerr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err && !tx_err_clr) |=> tx_err);

  p_rxerr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err && !rx_err_clr) |=> rx_err);

  p_standby_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_run |=> !ready);

  p_sync_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(sync_rd));
endmodule

bind audio_fifo_dreq afifo_dreq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick       (sclk_tick_i),
  .flush      (flush),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .tx_err     (tx_err_q),
  .rx_err     (rx_err_q),
  .tx_err_clr (tx_err_clr),
  .rx_err_clr (rx_err_clr),
  .en_run     (en_run),
  .ready      (ready),
  .sync_rd    (sync_rd)
);

// File: tb/audio_fifo_dreq_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_dreq_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_tick_i = 1'b0;
  logic reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic [31:0] tx_data_o, rx_data_i = '0;
  logic tx_dreq_o, tx_panic_o, rx_dreq_o, rx_panic_o;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  localparam logic [31:0] CTL_ON = 32'h0002_0007;

  always #2.5 clk_i = ~clk_i;

  audio_fifo_dreq dut_i (.*);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk_i); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    cyc(); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; reg_re_i = (a == 2'd1); #1; d = reg_rdata_o;
    cyc(); reg_re_i = 1'b0;
  endtask

  task automatic rbit(input int k, output logic [31:0] b);
    logic [31:0] v; rd(2'd0, v); b = {31'd0, v[k]};
  endtask

  task automatic tick(); sclk_tick_i = 1'b1; cyc(); sclk_tick_i = 1'b0; endtask

  task automatic pop(output logic [31:0] d);
    tx_pop_i = 1'b1; #1; d = tx_data_o; cyc(); tx_pop_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    rx_data_i = d; rx_push_i = 1'b1; cyc(); rx_push_i = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(2'd0, v);
    chk("R1 ctrl reset", v, 32'h0000_5000);
    chk("R1 outputs", {28'd0, tx_dreq_o, tx_panic_o, rx_dreq_o, rx_panic_o}, 32'd0);
  endtask

  task automatic test_standby();
    logic [31:0] b;
    wr(2'd0, CTL_ON);
    push(32'h11);
    rbit(13, b); chk("R3 push ignored before ready", b, 0);
    rbit(11, b); chk("R3 no error before ready", b, 0);
    for (int i = 0; i < 3; i++) tick();
    rbit(18, b); chk("R4 not ready after 3 ticks", b, 0);
    tick();
    rbit(18, b); chk("R4 ready after 4 ticks", b, 1);
  endtask

  task automatic test_tx_path();
    logic [31:0] d, b;
    wr(2'd1, 32'hA1); wr(2'd1, 32'hB2); wr(2'd1, 32'hC3);
    rbit(12, b); chk("R11 tx not empty", b, 0);
    pop(d); chk("R2 tx order 0", d, 32'hA1);
    pop(d); chk("R2 tx order 1", d, 32'hB2);
    pop(d); chk("R2 tx order 2", d, 32'hC3);
    rbit(12, b); chk("R11 tx empty", b, 1);
    wr(2'd1, 32'hD4);
    wr(2'd0, CTL_ON & ~32'h4);
    pop(d); pop(d);
    chk("R3 tx pop ignored when off", tx_data_o, 32'hD4);
    rbit(10, b); chk("R3 no underrun when off", b, 0);
    wr(2'd0, CTL_ON);
    pop(d); chk("R2 tx after re-enable", d, 32'hD4);
  endtask

  task automatic test_rx_path();
    logic [31:0] d, b;
    push(32'h100); push(32'h200); push(32'h300);
    rbit(13, b); chk("R11 rx holds data", b, 1);
    rd(2'd1, d); chk("R2 rx order 0", d, 32'h100);
    rd(2'd1, d); chk("R2 rx order 1", d, 32'h200);
    rd(2'd1, d); chk("R2 rx order 2", d, 32'h300);
    rd(2'd1, d); chk("R2 rx empty read", d, 0);
    rbit(13, b); chk("R11 rx drained", b, 0);
  endtask

  task automatic test_clear();
    logic [31:0] b;
    for (int i = 0; i < 5; i++) wr(2'd1, i);
    wr(2'd0, CTL_ON | 32'h8);
    rbit(12, b); chk("R5 tx clr no ticks", b, 0);
    tick();
    rbit(12, b); chk("R5 tx clr one tick", b, 0);
    tick();
    rbit(12, b); chk("R5 tx clr two ticks", b, 1);
    push(1); push(2);
    wr(2'd0, CTL_ON | 32'h10);
    tick();
    rbit(13, b); chk("R5 rx clr one tick", b, 1);
    tick();
    rbit(13, b); chk("R5 rx clr two ticks", b, 0);
  endtask

  task automatic test_sync();
    logic [31:0] b;
    wr(2'd0, CTL_ON | 32'h1_0000);
    rbit(16, b); chk("R6 sync no ticks", b, 0);
    tick();
    rbit(16, b); chk("R6 sync one tick", b, 0);
    tick();
    rbit(16, b); chk("R6 sync two ticks", b, 1);
    wr(2'd0, CTL_ON);
    tick();
    rbit(16, b); chk("R6 sync low one tick", b, 1);
    tick();
    rbit(16, b); chk("R6 sync low two ticks", b, 0);
  endtask

  task automatic test_errors();
    logic [31:0] d, b;
    pop(d);
    rbit(10, b); chk("R7 underrun set", b, 1);
    wr(2'd0, CTL_ON);
    rbit(10, b); chk("R7 underrun sticky", b, 1);
    wr(2'd0, CTL_ON | 32'h400);
    rbit(10, b); chk("R7 underrun cleared", b, 0);
    for (int i = 0; i < 64; i++) push(i);
    rbit(11, b); chk("R8 no overrun at 64", b, 0);
    push(32'hDEAD);
    rbit(11, b); chk("R8 overrun set", b, 1);
    rd(2'd1, d); chk("R8 first word kept", d, 0);
    for (int i = 1; i < 63; i++) rd(2'd1, d);
    rd(2'd1, d); chk("R8 last word kept", d, 63);
    rd(2'd1, d); chk("R8 extra word dropped", d, 0);
    wr(2'd0, CTL_ON | 32'h800);
    rbit(11, b); chk("R8 overrun cleared", b, 0);
  endtask

  task automatic test_thresholds();
    logic [31:0] b;
    wr(2'd0, CTL_ON | 32'h40);
    rbit(14, b); chk("R9 tx need empty", b, 1);
    for (int i = 0; i < 31; i++) wr(2'd1, i);
    rbit(14, b); chk("R9 tx need at 31", b, 1);
    wr(2'd1, 31);
    rbit(14, b); chk("R9 tx need at 32", b, 0);
    wr(2'd0, CTL_ON | 32'h48); tick(); tick();
    wr(2'd0, CTL_ON | 32'h80);
    for (int i = 0; i < 15; i++) push(i);
    rbit(15, b); chk("R9 rx need at 15", b, 0);
    push(15);
    rbit(15, b); chk("R9 rx need at 16", b, 1);
    wr(2'd0, CTL_ON | 32'h90); tick(); tick();
    wr(2'd0, CTL_ON);
  endtask

  task automatic test_dreq();
    logic [31:0] d;
    wr(2'd2, 32'h0205_0402);
    rd(2'd2, d); chk("R10 level readback", d, 32'h0205_0402);
    chk("R10 gated off", {28'd0, tx_dreq_o, tx_panic_o, rx_dreq_o, rx_panic_o}, 0);
    wr(2'd0, CTL_ON | 32'h200);
    chk("R10 tx empty lines", {30'd0, tx_dreq_o, tx_panic_o}, 32'h3);
    for (int i = 0; i < 3; i++) wr(2'd1, i);
    chk("R10 tx at 3", {30'd0, tx_dreq_o, tx_panic_o}, 32'h2);
    wr(2'd1, 3);
    chk("R10 tx at 4", {30'd0, tx_dreq_o, tx_panic_o}, 32'h0);
    pop(d); pop(d); pop(d);
    chk("R10 tx at 1", {30'd0, tx_dreq_o, tx_panic_o}, 32'h3);
    push(1); push(2);
    chk("R10 rx at 2", {30'd0, rx_dreq_o, rx_panic_o}, 32'h0);
    push(3);
    chk("R10 rx at 3", {30'd0, rx_dreq_o, rx_panic_o}, 32'h2);
    push(4); push(5); push(6);
    chk("R10 rx at 6", {30'd0, rx_dreq_o, rx_panic_o}, 32'h3);
    wr(2'd0, CTL_ON);
    chk("R10 dma disabled", {28'd0, tx_dreq_o, tx_panic_o, rx_dreq_o, rx_panic_o}, 0);
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    cyc();
    test_reset();
    test_standby();
    test_tx_path();
    test_rx_path();
    test_clear();
    test_sync();
    test_errors();
    test_thresholds();
    test_dreq();
    summary();
  end
endmodule